// File: doc/BRIEF.md
# Random Access Scan Cell Array

This block gives test access to a bank of storage flip-flops one cell at a time. It does not shift a serial chain. A test controller first streams a cell address into a staging register. It then strobes an update, and the update registers a one-hot select from that address. Once a cell is selected, the controller can read it on the shared test output or overwrite it from the test input. No other flip-flop changes during the access. The logic fed by the array therefore sees no switching activity during test.

In functional mode every cell captures its functional data input on each clock and the test path stays idle. The shared test output is built as an AND-OR tree over the per-cell select lines. It behaves like a bus with a single driver. When no cell is selected, the output sits at 0.

Top module: `ras_cell_array`

## Requirements
- R1: After the asynchronous active-low reset, every cell holds 0, the staging register holds 0, cell 0 is selected and `tdo_o` is 0.
- R2: While `addr_shift_i` is high, each clock shifts `tdi_i` into the most significant bit of the staging register, so the first bit shifted ends up as address bit 0 after ADDR_W shifts. The active selection changes only on a clock with `addr_update_i` high. That clock takes the staging value as it was before the same edge.
- R3: At most one cell is selected at any time. Cell k is selected exactly when the last updated address equals k, and an address of NUM_CELLS or above selects no cell.
- R4: With `test_mode_i`=1 and `wr_en_i`=1, the selected cell stores `tdi_i` at the clock edge.
- R5: With `test_mode_i`=1, every cell that is not both selected and write-enabled keeps its value across the edge, whatever `tdi_i` does.
- R6: `tdo_o` shows the stored bit of the selected cell combinationally.
- R7: With an address of NUM_CELLS or above, `tdo_o` is 0 and a write changes no cell.
- R8: With `test_mode_i`=0, every cell loads its bit of `func_d_i` at each edge, and `wr_en_i` and `tdi_i` have no effect.
- R9: `func_q_o[k]` is the stored bit of cell k at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test/functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | 1 selects the test access path, 0 selects functional capture |
| func_d_i | input | NUM_CELLS | Functional data, one bit per cell |
| func_q_o | output | NUM_CELLS | Cell contents driving the attached logic |
| tdi_i | input | 1 | Serial test data input, used for the address and for writes |
| addr_shift_i | input | 1 | Shift strobe for the address staging register |
| addr_update_i | input | 1 | Update strobe that registers the one-hot select |
| wr_en_i | input | 1 | Write strobe for the selected cell |
| tdo_o | output | 1 | Test output from the selected cell |

## Verification
Single writes go to the first cell, a middle cell and the last cell. Each check compares the whole `func_q_o` vector, so a write that lands on the wrong cell or spills onto a neighbour shows up. A walk writes an alternating pattern to every address and reads each one back. This separates decoder aliasing from a bad bit order in the address. Other steps check that a shifted address takes no effect before its update, that `tdi_i` toggling without a write strobe is ignored, and that an out-of-range address reads 0 and cannot write. Two opposite functional patterns, applied while `wr_en_i` is held high, show that the functional path wins in functional mode.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_TEST = 1'b1
  } cell_mode_e;
endpackage

// File: rtl/ras_addr_shift.sv
module ras_addr_shift #(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              tdi_i,
  output logic [ADDR_W-1:0] stage_o
);
  logic [ADDR_W-1:0] stage_q;

  generate
    if (ADDR_W == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)      stage_q <= '0;
        else if (shift_i) stage_q <= tdi_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)      stage_q <= '0;
        else if (shift_i) stage_q <= {tdi_i, stage_q[ADDR_W-1:1]};
    end
  endgenerate

  assign stage_o = stage_q;

  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> stage_o[ADDR_W-1] == $past(tdi_i));
  p_shift_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(stage_o));
endmodule

// File: rtl/ras_decoder.sv
module ras_decoder #(
  parameter int NUM_CELLS = 24,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 update_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_CELLS-1:0] sel_o
);
  logic [NUM_CELLS-1:0] dec;
  logic [NUM_CELLS-1:0] sel_q;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_dec
    assign dec[i] = (addr_i == ADDR_W'(i));
  end

  // select is registered: the decode only moves on an update strobe
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       sel_q <= NUM_CELLS'(1);
    else if (update_i) sel_q <= dec;

  assign sel_o = sel_q;

  p_onehot_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> ((sel_o != '0) == ($past(addr_i) < ADDR_W'(NUM_CELLS))));
  p_sel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(sel_o));
endmodule

// File: rtl/ras_cell.sv
module ras_cell
  import ras_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cell_mode_e mode_i,
  input  logic       func_d_i,
  input  logic       tdi_i,
  input  logic       sel_i,
  input  logic       wr_en_i,
  output logic       q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       q_q <= 1'b0;
    else if (mode_i == MODE_FUNC)      q_q <= func_d_i;
    else if (sel_i && wr_en_i)         q_q <= tdi_i;

  assign q_o = q_q;

  p_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TEST && sel_i && wr_en_i) |=> q_o == $past(tdi_i));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TEST && !(sel_i && wr_en_i)) |=> $stable(q_o));
  p_func_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FUNC) |=> q_o == $past(func_d_i));
endmodule

// File: rtl/ras_tdo_mux.sv
module ras_tdo_mux #(
  parameter int NUM_CELLS = 24
) (
  input  logic [NUM_CELLS-1:0] sel_i,
  input  logic [NUM_CELLS-1:0] q_i,
  output logic                 tdo_o
);
  // one-hot AND-OR stands in for the per-cell tri-state drivers
  assign tdo_o = |(sel_i & q_i);
endmodule

// File: rtl/ras_cell_array.sv
module ras_cell_array
  import ras_pkg::*;
#(
  parameter int NUM_CELLS = 24,
  parameter int ADDR_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 test_mode_i,
  input  logic [NUM_CELLS-1:0] func_d_i,
  output logic [NUM_CELLS-1:0] func_q_o,
  input  logic                 tdi_i,
  input  logic                 addr_shift_i,
  input  logic                 addr_update_i,
  input  logic                 wr_en_i,
  output logic                 tdo_o
);
  logic [ADDR_W-1:0]    stage;
  logic [NUM_CELLS-1:0] sel;
  logic [NUM_CELLS-1:0] cell_q;
  cell_mode_e           mode;

  assign mode = test_mode_i ? MODE_TEST : MODE_FUNC;

  ras_addr_shift #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (addr_shift_i),
    .tdi_i   (tdi_i),
    .stage_o (stage)
  );

  ras_decoder #(.NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .update_i (addr_update_i),
    .addr_i   (stage),
    .sel_o    (sel)
  );

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    ras_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode),
      .func_d_i (func_d_i[i]),
      .tdi_i    (tdi_i),
      .sel_i    (sel[i]),
      .wr_en_i  (wr_en_i),
      .q_o      (cell_q[i])
    );
  end

  ras_tdo_mux #(.NUM_CELLS(NUM_CELLS)) u_mux (
    .sel_i (sel),
    .q_i   (cell_q),
    .tdo_o (tdo_o)
  );

  assign func_q_o = cell_q;

  p_nomatch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == '0) |-> !tdo_o);
  p_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel != '0) |-> (tdo_o == |(sel & func_q_o)));
  p_write_isolated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode_i && !wr_en_i) |=> $stable(func_q_o));
endmodule

// File: tb/sim_ras_cell_array.sv
module sim_ras_cell_array;
  localparam int N = 24;
  localparam int W = 5;

  typedef struct {
    logic         tdo;
    logic [N-1:0] q;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0;
  logic [N-1:0] func_d = '0;
  logic [N-1:0] func_q;
  logic tdi = 1'b0;
  logic addr_shift = 1'b0;
  logic addr_update = 1'b0;
  logic wr_en = 1'b0;
  logic tdo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];

  // reference model
  logic [N-1:0] m_cells = '0;
  logic [W-1:0] m_stage = '0;
  int           m_addr  = 0;

  always #5 clk = ~clk;

  ras_cell_array #(.NUM_CELLS(N), .ADDR_W(W)) u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .test_mode_i   (test_mode),
    .func_d_i      (func_d),
    .func_q_o      (func_q),
    .tdi_i         (tdi),
    .addr_shift_i  (addr_shift),
    .addr_update_i (addr_update),
    .wr_en_i       (wr_en),
    .tdo_o         (tdo)
  );

  function automatic logic m_tdo();
    return (m_addr < N) ? m_cells[m_addr] : 1'b0;
  endfunction

  task automatic tick();
    logic [N-1:0] nc = m_cells;
    logic [W-1:0] ns = m_stage;
    int           na = m_addr;
    if (!test_mode) nc = func_d;
    else if (wr_en && m_addr < N) nc[m_addr] = tdi;
    if (addr_shift) ns = {tdi, m_stage[W-1:1]};
    if (addr_update) na = int'(m_stage);
    @(posedge clk); #1;
    m_cells = nc; m_stage = ns; m_addr = na;
  endtask

  task automatic expect_now(string tag);
    exp_t e;
    e.tdo = m_tdo(); e.q = m_cells; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic shift_addr(int a);
    for (int i = 0; i < W; i++) begin
      addr_shift = 1'b1; tdi = a[i];
      tick();
    end
    addr_shift = 1'b0;
  endtask

  task automatic load_addr(int a);
    shift_addr(a);
    addr_update = 1'b1;
    tick();
    addr_update = 1'b0;
  endtask

  task automatic write_bit(logic v);
    tdi = v; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  // monitor: pops one expectation per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (tdo !== e.tdo || func_q !== e.q) begin
        errors++;
        $display("FAIL %s tdo=%b exp=%b cells=%h exp=%h", e.tag, tdo, e.tdo, func_q, e.q);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_now("R1 reset state");
    tick();
    test_mode = 1'b1;

    load_addr(0);  write_bit(1'b1); expect_now("R4 R5 write first cell");
    load_addr(5);  write_bit(1'b1); expect_now("R4 R5 write middle cell");
    load_addr(23); write_bit(1'b1); expect_now("R4 R5 write last cell");
    load_addr(5);  write_bit(1'b0); expect_now("R4 R5 clear middle cell");

    load_addr(23); expect_now("R6 read last cell");
    load_addr(0);  expect_now("R6 read first cell");

    shift_addr(7); expect_now("R2 shift without update keeps selection");
    addr_update = 1'b1; tick(); addr_update = 1'b0;
    expect_now("R2 R3 update switches selection");

    load_addr(27); expect_now("R7 out of range reads zero");
    write_bit(1'b1); expect_now("R7 out of range write ignored");

    load_addr(0);
    for (int i = 0; i < 4; i++) begin
      tdi = i[0]; tick();
    end
    expect_now("R5 tdi toggles without write strobe");

    for (int a = 0; a < N; a++) begin
      load_addr(a); write_bit(a[0] ^ a[2]);
      expect_now("R3 R4 walk write");
    end
    for (int a = 0; a < N; a++) begin
      load_addr(a); expect_now("R6 R9 walk read");
    end

    test_mode = 1'b0; wr_en = 1'b1; tdi = 1'b1;
    func_d = 24'h5A_C3_96; tick(); expect_now("R8 R9 functional pattern A");
    func_d = 24'hA5_3C_69; tick(); expect_now("R8 R9 functional pattern B");
    wr_en = 1'b0; test_mode = 1'b1;
    load_addr(2); expect_now("R6 read after functional load");
    load_addr(3); expect_now("R6 read after functional load");

    wait (sb.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule